// File: doc/BRIEF.md
# Hardwired Fetch/Execute Sequencer for a Four-Instruction Accumulator CPU

This block is the control unit of a small accumulator machine. It has a four-state step counter and a one-hot step decoder. A single phase flip-flop selects between instruction fetch and instruction execute. A one-hot decoder reads the two opcode bits of the instruction register. From the present phase, step and opcode it produces, within the same cycle, every transfer enable that the datapath needs: register loads, memory read and write strobes, ALU operand selects, the add command and the carry-in.

Each instruction takes a three-step fetch followed by an execute sequence whose length depends on the opcode. A jump takes one step, a store two, a load three and an add four. The step counter is cleared at the final step of every sequence, except an add, which reaches the last counter state and wraps around by itself. The datapath, the memory and the instruction register are outside the block. The block receives only the two opcode bits. All ports are plain control pins, so there is no stream handshake and no back-pressure.

Top module: `cu_hardwired`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block is in fetch step 1, and `mar_from_pc` is the only enable that is high.
- R2: Fetch lasts exactly three cycles, whatever the opcode. Step 1 raises `mar_from_pc`. Step 2 raises `mem_rd`, `mbr_from_mem`, `alu_sel_pc`, `alu_add` and `alu_cin`. Step 3 raises `pc_from_alu` and `ir_from_mbr`. After step 3 the block enters execute step 1. Exactly one step signal is active in any cycle.
- R3: The opcode input is bits 7:6 of the instruction word, encoded as 00 load, 01 add, 10 jump and 11 store.
- R4: Load execute takes three cycles. Step 1 raises `mar_from_ir`. Step 2 raises `mem_rd` and `mbr_from_mem`. Step 3 raises `ac_from_mbr`. The next cycle is fetch step 1.
- R5: Add execute takes four cycles. Step 1 raises `mar_from_ir`. Step 2 raises `mem_rd` and `mbr_from_mem`. Step 3 raises `alu_sel_mbr`, `alu_add` and `alu_buf_ld`. Step 4 raises `ac_from_alu`. The counter then wraps, and the next cycle is fetch step 1.
- R6: Store execute takes two cycles. Step 1 raises `mar_from_ir` and `mbr_from_ac` together. Step 2 raises `mem_wr` and `mbr_drive_mem`. The next cycle is fetch step 1.
- R7: Jump execute takes one cycle. It raises only `pc_from_ir`, and the next cycle is fetch step 1.
- R8: Execute enables are never raised during fetch, even when the opcode input still holds an add or another opcode from the previous instruction.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle. Every enable is a decode of the current phase, step and opcode, and it is valid in the cycle that step is active.
- R10: Asserting reset in the middle of an execute sequence returns the block at once to fetch step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_op | input | 2 | Opcode bits 7:6 of the instruction register |
| mar_from_pc | output | 1 | Load address register from program counter |
| mem_rd | output | 1 | Memory read strobe |
| mbr_from_mem | output | 1 | Load buffer register from memory |
| alu_sel_pc | output | 1 | Select program counter as ALU operand |
| alu_add | output | 1 | ALU add command |
| alu_cin | output | 1 | ALU carry-in |
| pc_from_alu | output | 1 | Load program counter from ALU buffer |
| ir_from_mbr | output | 1 | Load instruction register from buffer register |
| mar_from_ir | output | 1 | Load address register from instruction address field |
| mbr_from_ac | output | 1 | Load buffer register from accumulator |
| mem_wr | output | 1 | Memory write strobe |
| mbr_drive_mem | output | 1 | Drive buffer register onto memory data |
| alu_sel_mbr | output | 1 | Select buffer register as ALU operand |
| alu_buf_ld | output | 1 | Load ALU output buffer |
| ac_from_alu | output | 1 | Load accumulator from ALU buffer |
| ac_from_mbr | output | 1 | Load accumulator from buffer register |
| pc_from_ir | output | 1 | Load program counter from instruction address field |

## Verification
Each opcode is run after every other opcode. This shows that each execute sequence has its own length and its own early counter clear, and that control returns to fetch step 1 from each of them. An add following an add leaves a stale add on the opcode pins during fetch, which would expose any execute enable that is missing the phase qualifier. Opcode changes during fetch show that the fetch pattern does not depend on the opcode. A reset asserted during add step 2 separates the asynchronous return to fetch from the normal end of a sequence.

// File: rtl/cu_pkg.sv
package cu_pkg;
  localparam int OP_W      = 2;
  localparam int NUM_OPS   = 1 << OP_W;

  // one-hot index positions; the opcode index equals its encoding
  localparam int IX_LOAD  = 0;
  localparam int IX_ADD   = 1;
  localparam int IX_JUMP  = 2;
  localparam int IX_STORE = 3;

  localparam int IX_T1 = 0;
  localparam int IX_T2 = 1;
  localparam int IX_T3 = 2;
  localparam int IX_T4 = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_LOAD  = 2'b00,
    OPC_ADD   = 2'b01,
    OPC_JUMP  = 2'b10,
    OPC_STORE = 2'b11
  } opc_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mem_rd;
    logic mbr_from_mem;
    logic alu_sel_pc;
    logic alu_add;
    logic alu_cin;
    logic pc_from_alu;
    logic ir_from_mbr;
    logic mar_from_ir;
    logic mbr_from_ac;
    logic mem_wr;
    logic mbr_drive_mem;
    logic alu_sel_mbr;
    logic alu_buf_ld;
    logic ac_from_alu;
    logic ac_from_mbr;
    logic pc_from_ir;
  } ctrl_t;
endpackage

// File: rtl/cu_step_timer.sv
module cu_step_timer #(
  parameter int NUM_STEPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  output logic [NUM_STEPS-1:0] step_oh
);
  localparam int CNT_W = $clog2(NUM_STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_STEPS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_dec
    assign step_oh[g] = (cnt == CNT_W'(g));
  end

  // R2: exactly one step signal active
  p_step_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_oh) == 1);
endmodule

// File: rtl/cu_op_decode.sv
module cu_op_decode #(
  parameter int OP_W = 2
) (
  input  logic [OP_W-1:0]      opcode,
  output logic [(1<<OP_W)-1:0] op_oh
);
  for (genvar g = 0; g < (1 << OP_W); g++) begin : g_dec
    assign op_oh[g] = (opcode == OP_W'(g));
  end
endmodule

// File: rtl/cu_phase_reg.sv
module cu_phase_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_last,
  input  logic exec_last,
  output logic fetch
);
  logic fetch_nx;

  // stay in fetch until its last step; return when execute ends
  always_comb fetch_nx = fetch ? !fetch_last : exec_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch <= 1'b1;
    else        fetch <= fetch_nx;
  end

  // R2: fetch's final step hands over to execute
  p_fetch_to_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch && fetch_last |=> !fetch);
endmodule

// File: rtl/cu_enable_decode.sv
module cu_enable_decode
  import cu_pkg::*;
#(
  parameter int NUM_STEPS = 4
) (
  input  logic                 fetch,
  input  logic [NUM_STEPS-1:0] step_oh,
  input  logic [NUM_OPS-1:0]   op_oh,
  output ctrl_t                ctrl,
  output logic                 fetch_last,
  output logic                 exec_last,
  output logic                 clr_step
);
  logic ex, t1, t2, t3, t4, l, a, j, s;
  logic early_end;

  always_comb begin
    ex = !fetch;
    t1 = step_oh[IX_T1];
    t2 = step_oh[IX_T2];
    t3 = step_oh[IX_T3];
    t4 = step_oh[IX_T4];
    l  = op_oh[IX_LOAD];
    a  = op_oh[IX_ADD];
    j  = op_oh[IX_JUMP];
    s  = op_oh[IX_STORE];
  end

  always_comb begin
    fetch_last = fetch & t3;
    early_end  = ex & ((t1 & j) | (t2 & s) | (t3 & l));
    exec_last  = early_end | (ex & t4 & a);
  end

  // add ends on the last counter state only when the counter is four deep
  if (NUM_STEPS == 4) begin : g_wrap
    assign clr_step = fetch_last | early_end;
  end else begin : g_noclr
    assign clr_step = fetch_last | exec_last;
  end

  always_comb begin
    ctrl               = '0;
    ctrl.mar_from_pc   = fetch & t1;
    ctrl.mem_rd        = (fetch & t2) | (ex & t2 & (l | a));
    ctrl.mbr_from_mem  = (fetch & t2) | (ex & t2 & (l | a));
    ctrl.alu_sel_pc    = fetch & t2;
    ctrl.alu_add       = (fetch & t2) | (ex & t3 & a);
    ctrl.alu_cin       = fetch & t2;
    ctrl.pc_from_alu   = fetch & t3;
    ctrl.ir_from_mbr   = fetch & t3;
    ctrl.mar_from_ir   = ex & t1 & (l | a | s);
    ctrl.mbr_from_ac   = ex & t1 & s;
    ctrl.mem_wr        = ex & t2 & s;
    ctrl.mbr_drive_mem = ex & t2 & s;
    ctrl.alu_sel_mbr   = ex & t3 & a;
    ctrl.alu_buf_ld    = ex & t3 & a;
    ctrl.ac_from_alu   = ex & t4 & a;
    ctrl.ac_from_mbr   = ex & t3 & l;
    ctrl.pc_from_ir    = ex & t1 & j;
  end
endmodule

// File: rtl/cu_hardwired.sv
module cu_hardwired
  import cu_pkg::*;
#(
  parameter int NUM_STEPS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ir_op,
  output logic       mar_from_pc,
  output logic       mem_rd,
  output logic       mbr_from_mem,
  output logic       alu_sel_pc,
  output logic       alu_add,
  output logic       alu_cin,
  output logic       pc_from_alu,
  output logic       ir_from_mbr,
  output logic       mar_from_ir,
  output logic       mbr_from_ac,
  output logic       mem_wr,
  output logic       mbr_drive_mem,
  output logic       alu_sel_mbr,
  output logic       alu_buf_ld,
  output logic       ac_from_alu,
  output logic       ac_from_mbr,
  output logic       pc_from_ir
);
  logic [NUM_STEPS-1:0] step_oh;
  logic [NUM_OPS-1:0]   op_oh;
  logic                 fetch, fetch_last, exec_last, clr_step;
  ctrl_t                ctrl;

  cu_step_timer #(.NUM_STEPS(NUM_STEPS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr_step), .step_oh(step_oh));

  cu_op_decode #(.OP_W(OP_W)) u_opdec (.opcode(ir_op), .op_oh(op_oh));

  cu_phase_reg u_phase (
    .clk(clk), .rst_n(rst_n), .fetch_last(fetch_last),
    .exec_last(exec_last), .fetch(fetch));

  cu_enable_decode #(.NUM_STEPS(NUM_STEPS)) u_endec (
    .fetch(fetch), .step_oh(step_oh), .op_oh(op_oh), .ctrl(ctrl),
    .fetch_last(fetch_last), .exec_last(exec_last), .clr_step(clr_step));

  always_comb begin
    mar_from_pc   = ctrl.mar_from_pc;
    mem_rd        = ctrl.mem_rd;
    mbr_from_mem  = ctrl.mbr_from_mem;
    alu_sel_pc    = ctrl.alu_sel_pc;
    alu_add       = ctrl.alu_add;
    alu_cin       = ctrl.alu_cin;
    pc_from_alu   = ctrl.pc_from_alu;
    ir_from_mbr   = ctrl.ir_from_mbr;
    mar_from_ir   = ctrl.mar_from_ir;
    mbr_from_ac   = ctrl.mbr_from_ac;
    mem_wr        = ctrl.mem_wr;
    mbr_drive_mem = ctrl.mbr_drive_mem;
    alu_sel_mbr   = ctrl.alu_sel_mbr;
    alu_buf_ld    = ctrl.alu_buf_ld;
    ac_from_alu   = ctrl.ac_from_alu;
    ac_from_mbr   = ctrl.ac_from_mbr;
    pc_from_ir    = ctrl.pc_from_ir;
  end

  // R9: read and write strobes never overlap
  p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R8: no execute-only enable while fetching
  p_no_stale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> !(alu_buf_ld || ac_from_alu || mem_wr || pc_from_ir || ac_from_mbr));
  // R7: jump returns to fetch step 1 after one cycle
  p_jump_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_from_ir |=> fetch && step_oh[IX_T1]);
  // R6: store returns to fetch after its write step
  p_store_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> fetch && step_oh[IX_T1]);
  // R5: add wraps into fetch step 1
  p_add_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ac_from_alu |=> fetch && step_oh[IX_T1]);
  // R4: load returns to fetch after the accumulator load
  p_load_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ac_from_mbr |=> fetch && step_oh[IX_T1]);
endmodule

// File: tb/tb_cu_hardwired.sv
module tb_cu_hardwired;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ir_op = 2'b00;
  logic mar_from_pc, mem_rd, mbr_from_mem, alu_sel_pc, alu_add, alu_cin;
  logic pc_from_alu, ir_from_mbr, mar_from_ir, mbr_from_ac, mem_wr;
  logic mbr_drive_mem, alu_sel_mbr, alu_buf_ld, ac_from_alu, ac_from_mbr, pc_from_ir;

  always #5 clk = ~clk;

  cu_hardwired dut (
    .clk(clk), .rst_n(rst_n), .ir_op(ir_op),
    .mar_from_pc(mar_from_pc), .mem_rd(mem_rd), .mbr_from_mem(mbr_from_mem),
    .alu_sel_pc(alu_sel_pc), .alu_add(alu_add), .alu_cin(alu_cin),
    .pc_from_alu(pc_from_alu), .ir_from_mbr(ir_from_mbr),
    .mar_from_ir(mar_from_ir), .mbr_from_ac(mbr_from_ac), .mem_wr(mem_wr),
    .mbr_drive_mem(mbr_drive_mem), .alu_sel_mbr(alu_sel_mbr),
    .alu_buf_ld(alu_buf_ld), .ac_from_alu(ac_from_alu),
    .ac_from_mbr(ac_from_mbr), .pc_from_ir(pc_from_ir));

  // R3 encoding
  localparam logic [1:0] OP_LD = 2'b00, OP_AD = 2'b01, OP_JP = 2'b10, OP_ST = 2'b11;

  localparam logic [16:0] M_MARPC = 17'h10000, M_MRD = 17'h08000, M_MBRM = 17'h04000,
    M_SELPC = 17'h02000, M_ADD = 17'h01000, M_CIN = 17'h00800, M_PCALU = 17'h00400,
    M_IRMBR = 17'h00200, M_MARIR = 17'h00100, M_MBRAC = 17'h00080, M_MWR = 17'h00040,
    M_DRV = 17'h00020, M_SELMBR = 17'h00010, M_BUF = 17'h00008, M_ACALU = 17'h00004,
    M_ACMBR = 17'h00002, M_PCIR = 17'h00001;

  logic [16:0] q_vec[$];
  string       q_tag[$];
  int vectors = 0, misses = 0;
  bit done = 1'b0;

  function automatic logic [16:0] got_vec();
    return {mar_from_pc, mem_rd, mbr_from_mem, alu_sel_pc, alu_add, alu_cin,
            pc_from_alu, ir_from_mbr, mar_from_ir, mbr_from_ac, mem_wr,
            mbr_drive_mem, alu_sel_mbr, alu_buf_ld, ac_from_alu, ac_from_mbr, pc_from_ir};
  endfunction

  function automatic logic [16:0] fetch_exp(int s);
    case (s)
      1: return M_MARPC;
      2: return M_MRD | M_MBRM | M_SELPC | M_ADD | M_CIN;
      default: return M_PCALU | M_IRMBR;
    endcase
  endfunction

  function automatic int exec_len(logic [1:0] op);
    case (op)
      OP_JP: return 1;
      OP_ST: return 2;
      OP_LD: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [16:0] exec_exp(logic [1:0] op, int s);
    case (op)
      OP_LD: case (s) 1: return M_MARIR; 2: return M_MRD | M_MBRM; default: return M_ACMBR; endcase
      OP_AD: case (s) 1: return M_MARIR; 2: return M_MRD | M_MBRM;
                      3: return M_SELMBR | M_ADD | M_BUF; default: return M_ACALU; endcase
      OP_ST: case (s) 1: return M_MARIR | M_MBRAC; default: return M_MWR | M_DRV; endcase
      default: return M_PCIR;
    endcase
  endfunction

  function automatic string exec_tag(logic [1:0] op);
    case (op)
      OP_LD: return "R4 (R3 op 00)";
      OP_AD: return "R5 (R3 op 01)";
      OP_JP: return "R7 (R3 op 10)";
      default: return "R6 (R3 op 11)";
    endcase
  endfunction

  // driver: one cycle, drive opcode and push what the design must show
  task automatic drive_cycle(logic [1:0] op, logic [16:0] exp, string tag);
    ir_op = op;
    q_vec.push_back(exp);
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic run_instr(logic [1:0] op, logic [1:0] stale);
    for (int s = 1; s <= 3; s++)
      drive_cycle(stale, fetch_exp(s), (stale == OP_AD) ? "R8 fetch with stale add" : "R2 fetch");
    for (int s = 1; s <= exec_len(op); s++)
      drive_cycle(op, exec_exp(op, s), exec_tag(op));
  endtask

  // monitor: pop and compare mid-cycle
  always @(negedge clk) begin
    if (q_vec.size() > 0) begin
      logic [16:0] e;
      string t;
      e = q_vec.pop_front();
      t = q_tag.pop_front();
      vectors++;
      if (got_vec() !== e) begin
        misses++;
        $display("FAIL %s: enables %05h expected %05h", t, got_vec(), e);
      end
      vectors++;
      if (mem_rd && mem_wr) begin
        misses++;
        $display("FAIL R9: mem_rd=%b mem_wr=%b expected not both", mem_rd, mem_wr);
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev;
    @(posedge clk); #1;
    drive_cycle(OP_AD, M_MARPC, "R1 reset held");
    drive_cycle(OP_ST, M_MARPC, "R1 reset held, other opcode");
    rst_n = 1'b1;
    // first cycle after release is fetch step 1 (R1)
    run_instr(OP_LD, OP_ST);
    run_instr(OP_AD, OP_LD);
    run_instr(OP_AD, OP_AD);   // R8 stale add during fetch
    run_instr(OP_ST, OP_AD);
    run_instr(OP_ST, OP_ST);
    run_instr(OP_JP, OP_ST);
    run_instr(OP_JP, OP_JP);
    run_instr(OP_LD, OP_JP);
    // R10: reset in the middle of an add
    for (int s = 1; s <= 3; s++) drive_cycle(OP_LD, fetch_exp(s), "R2 fetch");
    drive_cycle(OP_AD, exec_exp(OP_AD, 1), "R5 add step 1");
    rst_n = 1'b0;
    drive_cycle(OP_AD, M_MARPC, "R10 reset during add");
    rst_n = 1'b1;
    run_instr(OP_AD, OP_AD);
    // every ordered pair of opcodes
    prev = OP_AD;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        run_instr(2'(a), prev);
        run_instr(2'(b), 2'(a));
        prev = 2'(b);
      end
    while (q_vec.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule